// File: doc/BRIEF.md
# Trigger Latency Window Buffer

This block delays the digitised samples of a set of time-multiplexed detector channels by a programmable trigger latency and, when a trigger accept comes in, reads out a short run of consecutive samples for every channel. Samples enter one per clock beat in ascending channel order. One full pass over all channels forms one beam crossing. Each crossing lands in the next slot of a circular store that is `MAX_DEPTH` crossings deep, so the latency can be lengthened just by raising that parameter. At the nominal 40 MHz crossing rate and 2.5 us latency, that needs 100 slots of 16-bit samples per channel. A full-size instance holds 128 channels.

An accept strobe captures the crossing that lies `cfg_latency` crossings behind the crossing being filled, and queues it. A reader takes queued windows in order. For each channel it emits `WIN` consecutive samples, with the channel id and the sample offset beside every word, on a valid/ready stream. The final word of a window carries a last flag. Writing never waits on the output, so a stalled consumer cannot disturb the samples still flowing in. If the queue already holds `QDEPTH` windows, a further accept is dropped and a sticky overflow flag is raised.

Top module: `lat_window_buffer`

## Requirements
- R1: After reset, `out_valid` and `ovf_flag` are both 0.
- R2: Each cycle with `smp_valid` high stores `smp_data` for the next channel, in ascending order from 0 to `NUM_CH-1`. The beat for channel `NUM_CH-1` completes the crossing, and the next beat starts a new crossing at channel 0.
- R3: An accept seen at a clock edge selects start crossing C−L. C is the index of the crossing being filled at that edge, and L is `cfg_latency` at that edge (legal range `WIN` to `MAX_DEPTH-1`). The window covers crossings C−L to C−L+`WIN`−1. Slot addressing wraps from `MAX_DEPTH-1` to 0.
- R4: A window is emitted as channel 0 with `out_index` 0 to `WIN-1`, then channel 1, and so on up to channel `NUM_CH-1`. `out_index` is the offset of the sample from the start crossing.
- R5: `out_last` is 1 on exactly one word per window: channel `NUM_CH-1`, index `WIN-1`.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_chan`, `out_index`, `out_sample` and `out_last` hold their values.
- R7: Samples keep being stored while the output is stalled. Windows read after a stall return the values written before and during it.
- R8: Up to `QDEPTH` accepted windows may be pending at once. They are emitted in arrival order, each exactly once.
- R9: An accept that arrives while `QDEPTH` windows are pending is discarded, and it sets `ovf_flag`. The flag stays 1 until reset.
- R10: The latency is captured at the accept edge. Changing `cfg_latency` afterwards does not alter windows already queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_latency | input | clog2(MAX_DEPTH) | Trigger latency in crossings |
| smp_valid | input | 1 | A sample is present for the next channel |
| smp_data | input | SAMPLE_W | Sample value |
| trig_accept | input | 1 | Single-cycle trigger accept |
| out_ready | input | 1 | Consumer can take a word |
| out_valid | output | 1 | Output word valid |
| out_chan | output | clog2(NUM_CH) | Channel of the output word |
| out_index | output | clog2(WIN) | Sample offset within the window |
| out_sample | output | SAMPLE_W | Sample value |
| out_last | output | 1 | Final word of a window |
| ovf_flag | output | 1 | Sticky: an accept was dropped |

## Verification
The checks assume two things about the inputs. First, every accept comes with a latency in the legal range. Second, the consumer drains a window before the writer laps its start slot, which is a condition on the sample rate, the output stalls and the latency. The stimulus feeds samples at a reduced duty cycle and uses latencies of at most 40 crossings in a 64-slot store. It issues accepts only when the reference model shows room in the queue, except in the deliberate overflow phase. Stall phases hold `out_ready` low for far fewer crossings than the remaining headroom, so every expected window still holds its original data when it is read.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

   // how a (slot, channel) pair becomes a flat store address
   typedef enum logic [0:0] {
      ADDR_PACKED = 1'b0,   // channel count is a power of two: concatenate
      ADDR_SCALED = 1'b1    // otherwise: slot * channels + channel
   } addr_mode_e;

   function automatic int unsigned min1_clog2(input int unsigned v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lwb_sample_store.sv
module lwb_sample_store
   import lwb_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned SLOT_W    = 6,
   parameter int unsigned CH_W      = 2
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [SLOT_W-1:0]   wr_slot,
   input  logic [CH_W-1:0]     wr_ch,
   input  logic [SAMPLE_W-1:0] wr_data,
   input  logic [SLOT_W-1:0]   rd_slot,
   input  logic [CH_W-1:0]     rd_ch,
   output logic [SAMPLE_W-1:0] rd_data
);

   localparam int unsigned ENTRIES = NUM_CH * MAX_DEPTH;
   localparam addr_mode_e  MODE    = (is_pow2(NUM_CH) && NUM_CH > 1) ? ADDR_PACKED : ADDR_SCALED;
   localparam int unsigned ADDR_W  = (MODE == ADDR_PACKED) ? SLOT_W + CH_W : min1_clog2(ENTRIES);
   localparam int unsigned MEM_N   = 2 ** ADDR_W;

   logic [SAMPLE_W-1:0] mem [MEM_N];
   logic [ADDR_W-1:0]   wr_addr;
   logic [ADDR_W-1:0]   rd_addr;

   generate
      if (MODE == ADDR_PACKED) begin : g_packed
         assign wr_addr = {wr_slot, wr_ch};
         assign rd_addr = {rd_slot, rd_ch};
      end else begin : g_scaled
         assign wr_addr = ADDR_W'(32'(wr_slot) * NUM_CH + 32'(wr_ch));
         assign rd_addr = ADDR_W'(32'(rd_slot) * NUM_CH + 32'(rd_ch));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // read before write: a same-edge write is seen from the next cycle on
   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lwb_write_track.sv
module lwb_write_track #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned SLOT_W    = 6,
   parameter int unsigned CH_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SLOT_W-1:0] latency,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [CH_W-1:0]   wr_ch,
   output logic [SLOT_W-1:0] trig_slot
);

   logic [SLOT_W-1:0] slot_q;
   logic [CH_W-1:0]   ch_q;
   logic [SLOT_W:0]   wrapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         ch_q   <= '0;
      end else if (smp_valid) begin
         if (ch_q == CH_W'(NUM_CH - 1)) begin
            ch_q   <= '0;
            slot_q <= (slot_q == SLOT_W'(MAX_DEPTH - 1)) ? '0 : slot_q + 1'b1;
         end else begin
            ch_q <= ch_q + 1'b1;
         end
      end
   end

   // start slot lies latency crossings behind the slot being filled
   assign wrapped = (SLOT_W + 1)'(slot_q) + (SLOT_W + 1)'(MAX_DEPTH) - (SLOT_W + 1)'(latency);

   always_comb begin
      if (slot_q >= latency) trig_slot = slot_q - latency;
      else                   trig_slot = wrapped[SLOT_W-1:0];
   end

   assign wr_slot = slot_q;
   assign wr_ch   = ch_q;

endmodule

// File: rtl/lwb_accept_fifo.sv
module lwb_accept_fifo
   import lwb_pkg::*;
#(
   parameter int unsigned SLOT_W = 6,
   parameter int unsigned QDEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [SLOT_W-1:0] push_slot,
   input  logic              pop,
   output logic [SLOT_W-1:0] head_slot,
   output logic              not_empty,
   output logic              full
);

   localparam int unsigned QPTR_W = min1_clog2(QDEPTH);
   localparam int unsigned QCNT_W = min1_clog2(QDEPTH + 1);

   logic [SLOT_W-1:0] ring [QDEPTH];
   logic [QPTR_W-1:0] wp_q, rp_q;
   logic [QCNT_W-1:0] level_q;
   logic              push;

   assign full      = (level_q == QCNT_W'(QDEPTH));
   assign not_empty = (level_q != '0);
   assign push      = push_req && !full;
   assign head_slot = ring[rp_q];

   function automatic logic [QPTR_W-1:0] step(input logic [QPTR_W-1:0] p);
      return (p == QPTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) ring[wp_q] <= push_slot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         level_q <= '0;
      end else begin
         if (push) wp_q <= step(wp_q);
         if (pop)  rp_q <= step(rp_q);
         case ({push, pop})
            2'b10:   level_q <= level_q + 1'b1;
            2'b01:   level_q <= level_q - 1'b1;
            default: level_q <= level_q;
         endcase
      end
   end

endmodule

// File: rtl/lwb_window_read.sv
module lwb_window_read #(
   parameter int unsigned SAMPLE_W  = 16,
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned WIN       = 5,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned SLOT_W    = 6,
   parameter int unsigned CH_W      = 2,
   parameter int unsigned IDX_W     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                head_valid,
   input  logic [SLOT_W-1:0]   head_slot,
   output logic                pop,
   output logic [SLOT_W-1:0]   rd_slot,
   output logic [CH_W-1:0]     rd_ch,
   input  logic [SAMPLE_W-1:0] rd_data,
   input  logic                out_ready,
   output logic                out_valid,
   output logic [CH_W-1:0]     out_chan,
   output logic [IDX_W-1:0]    out_index,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_last
);

   logic [IDX_W-1:0] idx_q;
   logic [CH_W-1:0]  ch_q;
   logic             load, idx_end, ch_end;
   logic [SLOT_W:0]  sum;

   assign load    = head_valid && (!out_valid || out_ready);
   assign idx_end = (idx_q == IDX_W'(WIN - 1));
   assign ch_end  = (ch_q == CH_W'(NUM_CH - 1));
   assign pop     = load && idx_end && ch_end;

   generate
      if (WIN > 1) begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    idx_q <= '0;
            else if (load) idx_q <= idx_end ? '0 : idx_q + 1'b1;
         end
      end else begin : g_single
         assign idx_q = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ch_q <= '0;
      else if (load && idx_end)  ch_q <= ch_end ? '0 : ch_q + 1'b1;
   end

   // slot of the sample = start slot + offset, modulo the store depth
   assign sum     = (SLOT_W + 1)'(head_slot) + (SLOT_W + 1)'(idx_q);
   assign rd_slot = (sum >= (SLOT_W + 1)'(MAX_DEPTH)) ? SLOT_W'(sum - (SLOT_W + 1)'(MAX_DEPTH))
                                                      : sum[SLOT_W-1:0];
   assign rd_ch   = ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_chan   <= '0;
         out_index  <= '0;
         out_sample <= '0;
         out_last   <= 1'b0;
      end else begin
         if (!out_valid || out_ready) out_valid <= head_valid;
         if (load) begin
            out_chan   <= ch_q;
            out_index  <= idx_q;
            out_sample <= rd_data;
            out_last   <= idx_end && ch_end;
         end
      end
   end

endmodule

// File: rtl/lat_window_buffer.sv
module lat_window_buffer
   import lwb_pkg::*;
#(
   parameter  int unsigned SAMPLE_W  = 16,
   parameter  int unsigned NUM_CH    = 4,
   parameter  int unsigned MAX_DEPTH = 64,
   parameter  int unsigned WIN       = 5,
   parameter  int unsigned QDEPTH    = 4,
   localparam int unsigned SLOT_W    = min1_clog2(MAX_DEPTH),
   localparam int unsigned CH_W      = min1_clog2(NUM_CH),
   localparam int unsigned IDX_W     = min1_clog2(WIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SLOT_W-1:0]   cfg_latency,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                trig_accept,
   input  logic                out_ready,
   output logic                out_valid,
   output logic [CH_W-1:0]     out_chan,
   output logic [IDX_W-1:0]    out_index,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_last,
   output logic                ovf_flag
);

   generate
      if (SAMPLE_W < 1)                   begin : g_bad_width  $error("SAMPLE_W must be at least 1"); end
      if (NUM_CH < 1)                     begin : g_bad_ch     $error("NUM_CH must be at least 1"); end
      if (WIN < 1 || WIN >= MAX_DEPTH)    begin : g_bad_win    $error("WIN must lie in 1..MAX_DEPTH-1"); end
      if (QDEPTH < 1)                     begin : g_bad_queue  $error("QDEPTH must be at least 1"); end
   endgenerate

   logic [SLOT_W-1:0]   wr_slot, trig_slot, head_slot, rd_slot;
   logic [CH_W-1:0]     wr_ch, rd_ch;
   logic [SAMPLE_W-1:0] rd_data;
   logic                q_not_empty, q_full, q_pop;
   logic                ovf_q;

   lwb_write_track #(
      .NUM_CH(NUM_CH), .MAX_DEPTH(MAX_DEPTH), .SLOT_W(SLOT_W), .CH_W(CH_W)
   ) u_wtrk (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .latency(cfg_latency),
      .wr_slot(wr_slot), .wr_ch(wr_ch), .trig_slot(trig_slot)
   );

   lwb_sample_store #(
      .SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .MAX_DEPTH(MAX_DEPTH), .SLOT_W(SLOT_W), .CH_W(CH_W)
   ) u_store (
      .clk(clk), .wr_en(smp_valid), .wr_slot(wr_slot), .wr_ch(wr_ch), .wr_data(smp_data),
      .rd_slot(rd_slot), .rd_ch(rd_ch), .rd_data(rd_data)
   );

   lwb_accept_fifo #(
      .SLOT_W(SLOT_W), .QDEPTH(QDEPTH)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_req(trig_accept), .push_slot(trig_slot), .pop(q_pop),
      .head_slot(head_slot), .not_empty(q_not_empty), .full(q_full)
   );

   lwb_window_read #(
      .SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .WIN(WIN), .MAX_DEPTH(MAX_DEPTH),
      .SLOT_W(SLOT_W), .CH_W(CH_W), .IDX_W(IDX_W)
   ) u_read (
      .clk(clk), .rst_n(rst_n), .head_valid(q_not_empty), .head_slot(head_slot), .pop(q_pop),
      .rd_slot(rd_slot), .rd_ch(rd_ch), .rd_data(rd_data), .out_ready(out_ready),
      .out_valid(out_valid), .out_chan(out_chan), .out_index(out_index),
      .out_sample(out_sample), .out_last(out_last)
   );

   // dropped accepts leave a mark that only reset removes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ovf_q <= 1'b0;
      else if (trig_accept && q_full)   ovf_q <= 1'b1;
   end

   assign ovf_flag = ovf_q;

endmodule

// File: rtl/lat_window_buffer_chk.sv
module lat_window_buffer_chk #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned MAX_DEPTH = 64,
   parameter int unsigned WIN       = 5,
   parameter int unsigned SLOT_W    = 6,
   parameter int unsigned CH_W      = 2,
   parameter int unsigned IDX_W     = 3,
   parameter int unsigned SAMPLE_W  = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SLOT_W-1:0]   cfg_latency,
   input logic                trig_accept,
   input logic                q_full,
   input logic                out_ready,
   input logic                out_valid,
   input logic [CH_W-1:0]     out_chan,
   input logic [IDX_W-1:0]    out_index,
   input logic [SAMPLE_W-1:0] out_sample,
   input logic                out_last,
   input logic                ovf_flag
);

   // R1: the cycle reset is released, nothing is pending or flagged
   p_quiet_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && !ovf_flag));

   // R3: input assumption, latency legal whenever an accept is taken
   p_latency_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trig_accept |-> (cfg_latency >= SLOT_W'(WIN)) && (32'(cfg_latency) < MAX_DEPTH));

   // R4: tags stay inside the window shape
   p_tag_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (32'(out_index) < WIN) && (32'(out_chan) < NUM_CH));

   // R4: a window streams without gaps once started
   p_no_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=> out_valid);

   // R5: the last flag marks only the final channel's final offset
   p_last_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_chan == CH_W'(NUM_CH - 1)) && (out_index == IDX_W'(WIN - 1)));

   // R6: a refused word stays put
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_chan) && $stable(out_index)
                                     && $stable(out_sample) && $stable(out_last)));

   // R9: the flag only rises after an accept met a full queue
   p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ($past(trig_accept) && $past(q_full)));

   // R9: once raised the flag stays
   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

endmodule

bind lat_window_buffer lat_window_buffer_chk #(
   .NUM_CH(NUM_CH), .MAX_DEPTH(MAX_DEPTH), .WIN(WIN), .SLOT_W(SLOT_W),
   .CH_W(CH_W), .IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .trig_accept(trig_accept),
   .q_full(q_full), .out_ready(out_ready), .out_valid(out_valid), .out_chan(out_chan),
   .out_index(out_index), .out_sample(out_sample), .out_last(out_last), .ovf_flag(ovf_flag)
);

// File: tb/sim_lat_window_buffer.sv
`timescale 1ns/1ps
module sim_lat_window_buffer;

   localparam int NUM_CH    = 4;
   localparam int MAX_DEPTH = 64;
   localparam int WIN       = 5;
   localparam int QDEPTH    = 4;
   localparam int SLOT_W    = 6;
   localparam int CH_W      = 2;
   localparam int IDX_W     = 3;
   localparam int WORDS     = NUM_CH * WIN;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [SLOT_W-1:0] cfg_latency;
   logic              smp_valid;
   logic [15:0]       smp_data;
   logic              trig_accept;
   logic              out_ready;
   logic              out_valid;
   logic [CH_W-1:0]   out_chan;
   logic [IDX_W-1:0]  out_index;
   logic [15:0]       out_sample;
   logic              out_last;
   logic              ovf_flag;

   lat_window_buffer #(
      .SAMPLE_W(16), .NUM_CH(NUM_CH), .MAX_DEPTH(MAX_DEPTH), .WIN(WIN), .QDEPTH(QDEPTH)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_latency(cfg_latency), .smp_valid(smp_valid),
      .smp_data(smp_data), .trig_accept(trig_accept), .out_ready(out_ready),
      .out_valid(out_valid), .out_chan(out_chan), .out_index(out_index),
      .out_sample(out_sample), .out_last(out_last), .ovf_flag(ovf_flag)
   );

   always #2.5 clk = ~clk;   // 200 MHz

   typedef struct {
      int          ch;
      int          idx;
      logic [15:0] d;
      bit          last;
   } word_t;

   // reference model state
   logic [15:0] hist [int];
   word_t       exp_q [$];
   int          cross_cnt, wch, pend, loaded, windows_seen;
   bit          model_ovf;
   bit          hold_pend;
   int          h_ch, h_idx, h_last;
   logic [15:0] h_d;

   int          n_checks, n_fail;
   bit          feed_on;
   int          feed_pct, rdy_pct;
   bit          done;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   // sample source
   initial begin
      smp_valid = 1'b0;
      smp_data  = '0;
      forever begin
         @(negedge clk);
         if (feed_on && ($urandom_range(99) < feed_pct)) begin
            smp_valid = 1'b1;
            smp_data  = 16'($urandom);
         end else begin
            smp_valid = 1'b0;
         end
      end
   end

   // consumer
   initial begin
      out_ready = 1'b0;
      forever begin
         @(negedge clk);
         out_ready = ($urandom_range(99) < rdy_pct);
      end
   end

   // cycle-by-cycle reference, evaluated just before every rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            // R6: a word refused last edge must still be offered unchanged
            if (hold_pend) begin
               check(out_valid == 1'b1, "R6", "valid dropped during stall", out_valid, 1);
               check(out_chan == CH_W'(h_ch) && out_index == IDX_W'(h_idx) &&
                     out_sample == h_d && out_last == h_last[0],
                     "R6", "word changed during stall", out_sample, h_d);
            end
            hold_pend = out_valid && !out_ready;
            h_ch = out_chan; h_idx = out_index; h_d = out_sample; h_last = out_last;

            if (out_valid && out_ready) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R8", "word with no pending window", out_sample, 0);
               end else begin
                  word_t w;
                  w = exp_q.pop_front();
                  check(out_chan == CH_W'(w.ch), "R4", "channel order", out_chan, w.ch);
                  check(out_index == IDX_W'(w.idx), "R4", "sample offset", out_index, w.idx);
                  // R2 storage order, R3 latency address, R7 writes during stall, R10 latched latency
                  check(out_sample == w.d, "R3", "window sample", out_sample, w.d);
                  check(out_last == w.last, "R5", "last flag", out_last, w.last);
               end
               if (out_last) windows_seen++;
            end

            check(ovf_flag == model_ovf, "R9", "overflow flag", ovf_flag, model_ovf);

            begin
               bit ld, pushed;
               ld = (pend > 0) && (!out_valid || out_ready);
               pushed = 1'b0;
               if (trig_accept) begin
                  if (pend == QDEPTH) begin
                     model_ovf = 1'b1;
                  end else begin
                     int start;
                     pushed = 1'b1;
                     start  = cross_cnt - int'(cfg_latency);
                     for (int c = 0; c < NUM_CH; c++) begin
                        for (int i = 0; i < WIN; i++) begin
                           word_t w;
                           w.ch = c; w.idx = i;
                           w.d = hist[(start + i) * NUM_CH + c];
                           w.last = (c == NUM_CH - 1) && (i == WIN - 1);
                           exp_q.push_back(w);
                        end
                     end
                  end
               end
               if (ld) begin
                  loaded++;
                  if (loaded == WORDS) begin
                     loaded = 0;
                     pend--;
                  end
               end
               if (pushed) pend++;
            end

            if (smp_valid) begin
               hist[cross_cnt * NUM_CH + wch] = smp_data;
               if (wch == NUM_CH - 1) begin
                  wch = 0;
                  cross_cnt++;
               end else begin
                  wch++;
               end
            end
         end
      end
   end

   task automatic accept(input int lat);
      while (pend >= QDEPTH) @(negedge clk);
      cfg_latency = SLOT_W'(lat);
      trig_accept = 1'b1;
      @(negedge clk);
      trig_accept = 1'b0;
      cfg_latency = SLOT_W'(lat + 7);   // R10: later change must not matter
   endtask

   task automatic drain();
      while (exp_q.size() != 0 || pend != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      int seen0;
      rst_n = 1'b0; trig_accept = 1'b0; cfg_latency = SLOT_W'(5);
      feed_on = 1'b0; feed_pct = 100; rdy_pct = 100;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(ovf_flag == 1'b0, "R1", "ovf_flag after reset", ovf_flag, 0);

      // R2: fill more than one full lap of the store in channel order
      feed_on = 1'b1;
      while (cross_cnt < 70) @(negedge clk);

      // R3: several latencies, ready always high, half-rate samples
      feed_pct = 50;
      for (int k = 0; k < 9; k++) begin
         accept((k % 3 == 0) ? 5 : (k % 3 == 1) ? 17 : 40);
         repeat ($urandom_range(20, 3)) @(negedge clk);
      end
      drain();

      // R3: window straddling the top slot into slot 0
      while ((cross_cnt % MAX_DEPTH) != 2 || wch != 0) @(negedge clk);
      accept(5);
      // R3: subtraction wrapping below slot 0
      while ((cross_cnt % MAX_DEPTH) != 3) @(negedge clk);
      accept(40);
      drain();

      // R8: four back-to-back accepts with a random consumer
      rdy_pct = 60;
      for (int k = 0; k < QDEPTH; k++) accept(8 + k * 6);
      drain();
      check(exp_q.size() == 0, "R8", "queued windows all delivered", exp_q.size(), 0);

      // R7: long stall while samples keep arriving
      rdy_pct = 0;
      accept(20);
      repeat (80) @(negedge clk);
      rdy_pct = 100;
      drain();
      accept(5);   // covers crossings written during the stall
      drain();

      // R9: fill the queue behind a stalled consumer, then one more
      rdy_pct = 0;
      repeat (2) @(negedge clk);
      seen0 = windows_seen;
      for (int k = 0; k < QDEPTH + 1; k++) begin
         cfg_latency = SLOT_W'(10);
         trig_accept = 1'b1;
         @(negedge clk);
         trig_accept = 1'b0;
         repeat (2) @(negedge clk);
      end
      #2;
      check(ovf_flag == 1'b1, "R9", "flag after dropped accept", ovf_flag, 1);
      rdy_pct = 100;
      drain();
      check(windows_seen - seen0 == QDEPTH, "R9", "dropped accept produced no window",
            windows_seen - seen0, QDEPTH);
      repeat (10) @(negedge clk);
      #2;
      check(ovf_flag == 1'b1, "R9", "flag stays set", ovf_flag, 1);
      check(exp_q.size() == 0, "R8", "no leftover words", exp_q.size(), 0);

      finish_run();
   end

endmodule